// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This block follows every instruction through a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It keeps a valid flag, a PC and a small exception vector for each stage. A stage that detects a problem for the instruction it holds raises a strobe. That strobe only sets a bit in the instruction's vector. Nothing is acted on until the instruction reaches writeback.

When the writeback instruction carries any bit, the controller takes the exception in that same cycle. It flushes every stage latch to a bubble, so the faulting instruction and everything younger write nothing. It redirects fetch to a fixed trap address and records the faulting PC and a cause code. Instructions older than the faulting one have already retired normally. As a result, exceptions are reported in program order even when they are raised out of order.

Asynchronous interrupt lines pass through a synchronizer. Unless masked, a pending interrupt is tagged onto the instruction in decode and is then taken in order like any synchronous fault. A stall input freezes all stage latches.

Top module: `pec_ctrl`

## Requirements
- R1: With no stall and no exception taken, each stage latch passes its contents one stage forward per clock. `stage_we_o[k]` is high exactly when stage k (0 = fetch ... 4 = writeback) holds a valid instruction, no stall is applied and no exception is being taken.
- R2: A strobe on `exc_strobe_i[k]` (0 = fetch fault, 1 = undefined opcode, 2 = overflow, 3 = memory fault) sets a bit for the valid instruction then in stage k. It causes no flush until that instruction occupies writeback.
- R3: When the writeback vector has several bits set, the reported cause follows this priority. Interrupt is highest (code 5), then fetch fault (1), undefined opcode (2), overflow (3) and memory fault (4). Code 0 means no exception has been recorded.
- R4: In a cycle where the writeback instruction is valid and has any bit set, `flush_o` is 5'b11111 and all `stage_we_o` bits are 0. After that clock edge, every stage holds a bubble.
- R5: An instruction older than a faulting one retires with its write enable set, even if the younger one raised its exception first. Only the oldest faulting instruction is reported, and the vectors of squashed instructions are dropped.
- R6: On the clock edge that ends an exception-taking cycle, `epc_o` loads the PC of the writeback instruction and `cause_o` loads its code. Both hold their values at all other times.
- R7: In the exception-taking cycle, `redirect_o` is 1 and `redirect_pc_o` equals the TRAP_PC parameter. In every other cycle, `redirect_o` is 0.
- R8: Any `irq_i` line is seen after SYNC_STAGES clock edges. While `irq_mask_i` is 0, it sets the interrupt bit of the valid decode instruction on an advancing edge. While `irq_mask_i` is 1, it has no effect.
- R9: While `stall_i` is 1 and no exception is taken, all stage latches hold their values. Strobes in that cycle are ignored.
- R10: An exception in writeback is taken even while `stall_i` is 1. The flush overrides the stall.
- R11: While reset is asserted, all outputs except `redirect_pc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Freeze all stage latches |
| fetch_valid_i | input | 1 | An instruction enters fetch |
| fetch_pc_i | input | PC_W | PC of the entering instruction |
| exc_strobe_i | input | 4 | Per-stage exception strobes (fetch, decode, execute, memory) |
| irq_i | input | NUM_IRQ | Asynchronous interrupt lines |
| irq_mask_i | input | 1 | 1 disables interrupts |
| flush_o | output | 5 | Per-stage flush, bit 0 = fetch |
| stage_we_o | output | 5 | Per-stage write enable, bit 0 = fetch |
| epc_o | output | PC_W | PC of the last taken exception |
| cause_o | output | 3 | Cause code of the last taken exception |
| redirect_o | output | 1 | Fetch redirect to the trap entry |
| redirect_pc_o | output | PC_W | Trap entry address |

## Verification
The embedded properties check several things on every cycle:
- the pipeline is empty after any taken exception;
- the captured PC matches the instruction that was in writeback;
- the recorded cause is non-zero;
- latches stay frozen under stall;
- contents advance one stage per clock otherwise.

Some behaviour needs the bench's scenarios and its per-cycle reference model. This covers precise ordering when a younger instruction faults first, priority among several bits on one instruction, masking and synchronizer latency of interrupts, strobes dropped during stall, and a flush overriding a stall.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int unsigned NUM_STAGES = 5;
  localparam int unsigned EXC_W      = 5;
  // vector bit positions; bits 0..3 equal the index of the stage that posts them
  localparam int unsigned EXC_IF  = 0;
  localparam int unsigned EXC_ID  = 1;
  localparam int unsigned EXC_EX  = 2;
  localparam int unsigned EXC_MEM = 3;
  localparam int unsigned EXC_IRQ = 4;

  typedef logic [EXC_W-1:0] exc_vec_t;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_FETCH = 3'd1,
    CAUSE_UNDEF = 3'd2,
    CAUSE_OVF   = 3'd3,
    CAUSE_MEM   = 3'd4,
    CAUSE_IRQ   = 3'd5
  } cause_e;
endpackage

// File: rtl/pec_irq_sync.sv
module pec_irq_sync #(
  parameter int unsigned NUM_IRQ     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [NUM_IRQ-1:0] chain_q [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= irq_i;
      else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign irq_o = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/pec_stage_reg.sv
module pec_stage_reg
  import pec_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            hold_i,
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_i,
  input  exc_vec_t        exc_i,
  output logic            valid_o,
  output logic [PC_W-1:0] pc_o,
  output exc_vec_t        exc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pc_o    <= '0;
      exc_o   <= '0;
    end else if (flush_i) begin
      valid_o <= 1'b0;
      pc_o    <= '0;
      exc_o   <= '0;
    end else if (!hold_i) begin
      valid_o <= valid_i;
      pc_o    <= pc_i;
      exc_o   <= valid_i ? exc_i : '0;
    end
  end
endmodule

// File: rtl/pec_cause_sel.sv
module pec_cause_sel
  import pec_pkg::*;
(
  input  exc_vec_t vec_i,
  output logic     any_o,
  output cause_e   cause_o
);
  assign any_o = |vec_i;

  // interrupt precedes the instruction entirely, then stage order
  always_comb begin
    if      (vec_i[EXC_IRQ]) cause_o = CAUSE_IRQ;
    else if (vec_i[EXC_IF])  cause_o = CAUSE_FETCH;
    else if (vec_i[EXC_ID])  cause_o = CAUSE_UNDEF;
    else if (vec_i[EXC_EX])  cause_o = CAUSE_OVF;
    else if (vec_i[EXC_MEM]) cause_o = CAUSE_MEM;
    else                     cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/pec_ctrl.sv
module pec_ctrl
  import pec_pkg::*;
#(
  parameter int unsigned    PC_W        = 32,
  parameter int unsigned    NUM_IRQ     = 4,
  parameter int unsigned    SYNC_STAGES = 2,
  parameter logic [PC_W-1:0] TRAP_PC    = 'h80
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  stall_i,
  input  logic                  fetch_valid_i,
  input  logic [PC_W-1:0]       fetch_pc_i,
  input  logic [NUM_STAGES-2:0] exc_strobe_i,
  input  logic [NUM_IRQ-1:0]    irq_i,
  input  logic                  irq_mask_i,
  output logic [NUM_STAGES-1:0] flush_o,
  output logic [NUM_STAGES-1:0] stage_we_o,
  output logic [PC_W-1:0]       epc_o,
  output logic [2:0]            cause_o,
  output logic                  redirect_o,
  output logic [PC_W-1:0]       redirect_pc_o
);
  localparam int unsigned LAST = NUM_STAGES - 1;

  logic                  v_q   [NUM_STAGES];
  logic [PC_W-1:0]       pc_q  [NUM_STAGES];
  exc_vec_t              ex_q  [NUM_STAGES];
  logic                  v_d   [NUM_STAGES];
  logic [PC_W-1:0]       pc_d  [NUM_STAGES];
  exc_vec_t              ex_d  [NUM_STAGES];
  exc_vec_t              posted[NUM_STAGES-1];
  logic [NUM_STAGES-1:0] v_all;

  logic [NUM_IRQ-1:0] irq_sync;
  logic               irq_pend;
  logic               wb_any;
  cause_e             wb_cause;
  logic               take;

  pec_irq_sync #(.NUM_IRQ(NUM_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (irq_i),
    .irq_o (irq_sync)
  );

  assign irq_pend = (|irq_sync) & ~irq_mask_i;

  // bits posted by each stage onto the instruction it holds
  for (genvar k = 0; k < NUM_STAGES-1; k++) begin : g_post
    always_comb begin
      posted[k] = ex_q[k];
      if (v_q[k]) begin
        posted[k][k] = posted[k][k] | exc_strobe_i[k];
        if (k == EXC_ID) posted[k][EXC_IRQ] = posted[k][EXC_IRQ] | irq_pend;
      end
    end
  end

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign v_d[k]  = fetch_valid_i;
      assign pc_d[k] = fetch_pc_i;
      assign ex_d[k] = '0;
    end else begin : g_body
      assign v_d[k]  = v_q[k-1];
      assign pc_d[k] = pc_q[k-1];
      assign ex_d[k] = posted[k-1];
    end

    pec_stage_reg #(.PC_W(PC_W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flush_i(take),
      .hold_i (stall_i),
      .valid_i(v_d[k]),
      .pc_i   (pc_d[k]),
      .exc_i  (ex_d[k]),
      .valid_o(v_q[k]),
      .pc_o   (pc_q[k]),
      .exc_o  (ex_q[k])
    );

    assign v_all[k]      = v_q[k];
    assign stage_we_o[k] = v_q[k] & ~take & ~stall_i;
  end

  pec_cause_sel u_sel (
    .vec_i  (ex_q[LAST]),
    .any_o  (wb_any),
    .cause_o(wb_cause)
  );

  // flush wins over stall
  assign take          = v_q[LAST] & wb_any;
  assign flush_o       = {NUM_STAGES{take}};
  assign redirect_o    = take;
  assign redirect_pc_o = TRAP_PC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o   <= '0;
      cause_o <= CAUSE_NONE;
    end else if (take) begin
      epc_o   <= pc_q[LAST];
      cause_o <= wb_cause;
    end
  end

  // R4
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (v_all == '0));

  // R6
  epc_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (epc_o == $past(pc_q[LAST])));

  // R3
  cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (cause_o != 3'd0));

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !take) |=> $stable(v_all));

  // R1
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !take) |=> (v_all[NUM_STAGES-1:1] == $past(v_all[NUM_STAGES-2:0])));
endmodule

// File: tb/tb_pec_ctrl.sv
module tb_pec_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        stall;
  logic        fv;
  logic [31:0] fpc;
  logic [3:0]  strobe;
  logic [3:0]  irq;
  logic        mask;
  logic [4:0]  flush_o, stage_we_o;
  logic [31:0] epc_o, redirect_pc_o;
  logic [2:0]  cause_o;
  logic        redirect_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  string scen = "";

  // reference model state
  bit         mv[5];
  logic [31:0] mpc[5];
  logic [4:0]  mex[5];
  logic [3:0]  ms1, ms2;
  logic [31:0] mepc;
  logic [2:0]  mcause;

  always #10 clk = ~clk;

  pec_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .stall_i(stall), .fetch_valid_i(fv),
    .fetch_pc_i(fpc), .exc_strobe_i(strobe), .irq_i(irq), .irq_mask_i(mask),
    .flush_o(flush_o), .stage_we_o(stage_we_o), .epc_o(epc_o), .cause_o(cause_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] prio(input logic [4:0] e);
    if (e[4])      return 3'd5;
    else if (e[0]) return 3'd1;
    else if (e[1]) return 3'd2;
    else if (e[2]) return 3'd3;
    else if (e[3]) return 3'd4;
    return 3'd0;
  endfunction

  // called at a falling edge with inputs already driven
  task automatic cyc();
    bit         take, pend;
    logic [4:0] ewe, add;
    #1;
    take = mv[4] && (mex[4] != 5'd0);
    for (int k = 0; k < 5; k++) ewe[k] = mv[k] & !take & !stall;
    chk(flush_o == (take ? 5'h1f : 5'h0), {"R4 flush ", scen}, flush_o, take ? 5'h1f : 5'h0);
    chk(stage_we_o == ewe, {"R1 we ", scen}, stage_we_o, ewe);
    chk(redirect_o == take, {"R7 redirect ", scen}, redirect_o, take);
    if (take) chk(redirect_pc_o == 32'h80, {"R7 trap pc ", scen}, redirect_pc_o, 32'h80);
    chk(epc_o == mepc, {"R6 epc ", scen}, epc_o, mepc);
    chk(cause_o == mcause, {"R3 cause ", scen}, cause_o, mcause);
    pend = (|ms2) & !mask;
    if (take) begin
      mepc   = mpc[4];
      mcause = prio(mex[4]);
      for (int k = 0; k < 5; k++) begin mv[k] = 0; mpc[k] = 0; mex[k] = 0; end
    end else if (!stall) begin
      for (int k = 4; k > 0; k--) begin
        add = 5'd0;
        if (mv[k-1]) begin
          add[k-1] = strobe[k-1];
          if (k-1 == 1) add[4] = pend;
        end
        mv[k]  = mv[k-1];
        mpc[k] = mpc[k-1];
        mex[k] = mv[k-1] ? (mex[k-1] | add) : 5'd0;
      end
      mv[0] = fv; mpc[0] = fpc; mex[0] = 5'd0;
    end
    ms2 = ms1;
    ms1 = irq;
    @(negedge clk);
    if (!stall) fpc = fpc + 32'd4;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse(input logic [3:0] s);
    strobe = s; cyc(); strobe = 4'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; stall = 0; fv = 0; fpc = 32'h1000; strobe = 0; irq = 0; mask = 0;
    for (int k = 0; k < 5; k++) begin mv[k] = 0; mpc[k] = 0; mex[k] = 0; end
    ms1 = 0; ms2 = 0; mepc = 0; mcause = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(flush_o == 0 && stage_we_o == 0 && redirect_o == 0, "R11 reset ctrl", {flush_o, stage_we_o, redirect_o}, 0);
    chk(epc_o == 0 && cause_o == 0, "R11 reset regs", {epc_o[15:0], 13'd0, cause_o}, 0);
    @(negedge clk);
    rst_ni = 1;
    fv = 1;

    scen = "R1 clean stream";      run(10);
    scen = "R2 R5 overflow";       pulse(4'b0100); run(8);
    scen = "R5 younger same cycle"; run(5); pulse(4'b1001); run(8);
    scen = "R5 younger first";     run(5); pulse(4'b0001); pulse(4'b1000); run(8);
    scen = "R3 two bits one instr"; run(5); pulse(4'b0001); run(1); pulse(4'b0100); run(8);
    scen = "R3 undef vs mem";      run(5); pulse(4'b0010); run(1); pulse(4'b1000); run(8);
    scen = "R8 masked irq";        mask = 1; irq = 4'b0100; run(8); irq = 0; run(4); mask = 0; run(4);
    scen = "R8 unmasked irq";      irq = 4'b0001; cyc(); irq = 0; run(10);
    scen = "R8 irq plus fault";    run(3); irq = 4'b1000; pulse(4'b0001); irq = 0; run(10);
    scen = "R9 stall drops strobe"; run(5); stall = 1; strobe = 4'b0100; run(3); strobe = 0; stall = 0; run(8);
    scen = "R10 flush beats stall"; run(5); pulse(4'b1000); stall = 1; run(3); stall = 0; run(6);
    scen = "R1 bubbles";           fv = 0; run(3); fv = 1; run(2); fv = 0; run(2); fv = 1; run(6);

    scen = "random R2 R5 R8 R9 R10";
    for (int i = 0; i < 4000; i++) begin
      stall  = ($urandom % 5) == 0;
      fv     = ($urandom % 8) != 0;
      strobe = 4'd0;
      for (int s = 0; s < 4; s++) strobe[s] = ($urandom % 30) == 0;
      irq    = (($urandom % 60) == 0) ? 4'($urandom) : 4'd0;
      if (($urandom % 100) == 0) mask = ~mask;
      cyc();
    end
    stall = 0; strobe = 0; irq = 0; run(10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule